// File: doc/BRIEF.md
# Switchable-Width Static RAM Emulator

This block is a synthesizable memory core that behaves at its pins like an asynchronous static RAM, modelled at the cycle level. The pins are sampled on each rising clock edge and the read side answers one clock later. A configuration pin picks the organization at run time. When it is high, the array is word-wide: 16-bit words, with two active-low lane controls that gate the lower and upper bytes. When it is low, the array is byte-wide and twice as deep. One extra low address input then picks which half of the underlying word is accessed, and the byte always travels on the lower eight data bits.

Access is qualified by two enables of opposite polarity, an active-low write strobe and an active-low output drive. The bidirectional data bus is split into a write-data input, a read-data output and a per-lane drive flag, so a pad ring or a bench can rebuild a tri-state bus. An idle flag reports whenever the device is deselected. The array depth is a parameter, so a design can use a short array while keeping the same address mapping. The pins are plain level signals with no handshake. A new access may be presented on every clock and is never stalled.

Top module: `sram_emu`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `idle` is 1, `rdata_oe` is 00 and `rdata` is zero.
- R2: The device is selected only when `en_low_n`=0 and `en_high`=1. Otherwise, one cycle later `idle`=1 and `rdata_oe`=00, and the array is left unchanged.
- R3: In word mode (`wide_mode`=1), a selected cycle with `write_n`=0 stores `wdata[7:0]` if `lane_lo_n`=0 and stores `wdata[15:8]` if `lane_hi_n`=0. A lane whose control is high keeps its old contents.
- R4: In word mode, a selected cycle with `write_n`=1 and `drive_n`=0 gives the following result one cycle later: `rdata_oe[0]`=~`lane_lo_n`, `rdata_oe[1]`=~`lane_hi_n`, and each enabled lane shows its stored byte. A lane that is not driven reads as zero.
- R5: `drive_n` has no effect during a write: `rdata_oe` is 00 in the cycle after any selected write.
- R6: In word mode, when both lane controls are high the device counts as deselected: `idle`=1, nothing is written and nothing is driven.
- R7: In byte mode (`wide_mode`=0), the byte address is {`addr`, `half_sel`}. `half_sel`=0 selects bits 7:0 of word `addr` and `half_sel`=1 selects bits 15:8. The storage is the same one that word mode uses.
- R8: In byte mode, a write takes its byte from `wdata[7:0]`. A read gives `rdata_oe`=01 with the byte on `rdata[7:0]`, and `rdata[15:8]` is zero. The lane controls are ignored.
- R9: `half_sel` is ignored in word mode.
- R10: A selected cycle with `write_n`=1 and `drive_n`=1 gives `rdata_oe`=00 and `idle`=0, and it does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| wide_mode | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| en_low_n | input | 1 | Active-low device enable |
| en_high | input | 1 | Active-high device enable |
| write_n | input | 1 | Active-low write strobe |
| drive_n | input | 1 | Active-low read output drive |
| lane_lo_n | input | 1 | Active-low lower-byte lane control (word mode) |
| lane_hi_n | input | 1 | Active-low upper-byte lane control (word mode) |
| addr | input | ADDR_W | Word address |
| half_sel | input | 1 | Half select within the word, used in byte mode only |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on undriven lanes |
| rdata_oe | output | 2 | Per-lane drive flag: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| idle | output | 1 | High when the device is deselected |

## Verification
Word accesses are run with both lanes enabled, then with only the lower lane and only the upper lane. This shows whether the lane controls gate writes and read drive independently rather than together. The enables are put through every inactive combination, the output drive is held low during a write, and a selected cycle with no drive is tried. These patterns separate the three conditions: standby, write with its driver held off, and selected but quiet. Byte mode writes both halves of one word and reads them back in both organizations. This exposes a swapped half select, use of the wrong lane, or a mode-dependent address map, and toggling `half_sel` during word reads confirms that it is ignored.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef struct packed {
    logic             sel;
    logic             wr;
    logic             rd;
    logic             byte_mode;
    logic             half;
    logic [LANES-1:0] lane_wr;
    logic [LANES-1:0] lane_drv;
  } access_t;
endpackage

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
  import sram_emu_pkg::*;
(
  input  logic    wide_mode,
  input  logic    en_low_n,
  input  logic    en_high,
  input  logic    write_n,
  input  logic    drive_n,
  input  logic    lane_lo_n,
  input  logic    lane_hi_n,
  input  logic    half_sel,
  output access_t acc
);
  logic             chip_on;
  logic             lanes_off;
  logic [LANES-1:0] lane_pick;

  always_comb begin
    chip_on   = ~en_low_n & en_high;
    lanes_off = wide_mode & lane_lo_n & lane_hi_n;
    if (wide_mode) lane_pick = {~lane_hi_n, ~lane_lo_n};
    else           lane_pick = half_sel ? 2'b10 : 2'b01;

    acc           = '0;
    acc.sel       = chip_on & ~lanes_off;
    acc.wr        = acc.sel & ~write_n;
    acc.rd        = acc.sel & write_n & ~drive_n;
    acc.byte_mode = ~wide_mode;
    acc.half      = half_sel;
    acc.lane_wr   = acc.wr ? lane_pick : '0;
    if (acc.rd) acc.lane_drv = wide_mode ? lane_pick : 2'b01;
    else        acc.lane_drv = '0;
  end
endmodule

// File: rtl/sram_emu_bank.sv
module sram_emu_bank #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end
endmodule

// File: rtl/sram_emu_outstage.sv
module sram_emu_outstage
  import sram_emu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  access_t                acc,
  input  logic [LANES-1:0][LANE_W-1:0] bank_q,
  output logic [DATA_W-1:0]      rdata,
  output logic [LANES-1:0]       rdata_oe,
  output logic                   idle
);
  logic [LANES-1:0] drv_q;
  logic             byte_q;
  logic             half_q;
  logic             idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q  <= '0;
      byte_q <= 1'b0;
      half_q <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      drv_q  <= acc.lane_drv;
      byte_q <= acc.byte_mode;
      half_q <= acc.half;
      idle_q <= ~acc.sel;
    end
  end

  always_comb begin
    rdata = '0;
    if (byte_q) begin
      if (drv_q[0]) rdata[LANE_W-1:0] = bank_q[half_q];
    end else begin
      for (int l = 0; l < LANES; l++)
        if (drv_q[l]) rdata[l*LANE_W +: LANE_W] = bank_q[l];
    end
  end

  assign rdata_oe = drv_q;
  assign idle     = idle_q;
endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              en_low_n,
  input  logic              en_high,
  input  logic              write_n,
  input  logic              drive_n,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              half_sel,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        rdata_oe,
  output logic              idle
);
  access_t                      acc;
  logic [LANES-1:0][LANE_W-1:0] bank_q;

  sram_emu_decode u_decode (
    .wide_mode (wide_mode),
    .en_low_n  (en_low_n),
    .en_high   (en_high),
    .write_n   (write_n),
    .drive_n   (drive_n),
    .lane_lo_n (lane_lo_n),
    .lane_hi_n (lane_hi_n),
    .half_sel  (half_sel),
    .acc       (acc)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_wdata;
    assign lane_wdata = wide_mode ? wdata[l*LANE_W +: LANE_W] : wdata[LANE_W-1:0];

    sram_emu_bank #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_bank (
      .clk   (clk),
      .we    (acc.lane_wr[l]),
      .addr  (addr),
      .wdata (lane_wdata),
      .rdata (bank_q[l])
    );
  end

  sram_emu_outstage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .bank_q   (bank_q),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .idle     (idle)
  );
endmodule

// File: rtl/sram_emu_checker.sv
module sram_emu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wide_mode,
  input logic        en_low_n,
  input logic        en_high,
  input logic        write_n,
  input logic        drive_n,
  input logic        lane_lo_n,
  input logic        lane_hi_n,
  input logic [15:0] rdata,
  input logic [1:0]  rdata_oe,
  input logic        idle
);
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_low_n || !en_high) |=> (idle && rdata_oe == 2'b00)); // R2

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_low_n && en_high && !write_n) |=> (rdata_oe == 2'b00)); // R5

  AST_NO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && lane_lo_n && lane_hi_n) |=> idle); // R6

  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode) |=> (!rdata_oe[1] && rdata[15:8] == 8'h00)); // R8

  AST_WORD_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && !en_low_n && en_high && write_n && !drive_n && !lane_lo_n)
      |=> rdata_oe[0]); // R4

  AST_QUIET_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_low_n && en_high && write_n && drive_n && !(wide_mode && lane_lo_n && lane_hi_n))
      |=> (!idle && rdata_oe == 2'b00)); // R10
endmodule

bind sram_emu sram_emu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wide_mode (wide_mode),
  .en_low_n  (en_low_n),
  .en_high   (en_high),
  .write_n   (write_n),
  .drive_n   (drive_n),
  .lane_lo_n (lane_lo_n),
  .lane_hi_n (lane_hi_n),
  .rdata     (rdata),
  .rdata_oe  (rdata_oe),
  .idle      (idle)
);

// File: tb/sram_emu_bench.sv
module sram_emu_bench;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wide_mode, en_low_n, en_high, write_n, drive_n;
  logic              lane_lo_n, lane_hi_n, half_sel;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wdata;
  logic [15:0]       rdata;
  logic [1:0]        rdata_oe;
  logic              idle;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sram_emu #(.ADDR_W(ADDR_W)) u_sram_emu (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .en_low_n(en_low_n),
    .en_high(en_high), .write_n(write_n), .drive_n(drive_n),
    .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .addr(addr),
    .half_sel(half_sel), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .idle(idle)
  );

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {idle,oe,data}=%05h expected %05h", req, act, exp);
    end
  endtask

  // drive pins at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(input logic wide, input logic el_n, input logic eh, input logic w_n,
                     input logic d_n, input logic lo_n, input logic hi_n,
                     input logic [ADDR_W-1:0] a, input logic hs, input logic [15:0] d);
    wide_mode = wide; en_low_n = el_n; en_high = eh; write_n = w_n; drive_n = d_n;
    lane_lo_n = lo_n; lane_hi_n = hi_n; addr = a; half_sel = hs; wdata = d;
    @(negedge clk);
  endtask

  function automatic logic [18:0] obs();
    return {idle, rdata_oe, rdata};
  endfunction

  task automatic t_reset();
    chk("R1", obs(), {1'b1, 2'b00, 16'h0000});
    rst_n = 1'b1;
    cyc(1, 1, 0, 1, 1, 1, 1, 0, 0, 0);
    chk("R1", obs(), {1'b1, 2'b00, 16'h0000});
  endtask

  task automatic t_word_rw();
    cyc(1, 0, 1, 0, 1, 0, 0, 8'h12, 0, 16'hA55A);
    cyc(1, 0, 1, 0, 1, 0, 0, 8'hFF, 0, 16'h1234);
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h12, 0, 16'h0);
    chk("R3/R4 word read", obs(), {1'b0, 2'b11, 16'hA55A});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'hFF, 1, 16'h0);
    chk("R9 half_sel ignored in word mode", obs(), {1'b0, 2'b11, 16'h1234});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h12, 1, 16'h0);
    chk("R9 half_sel ignored in word mode", obs(), {1'b0, 2'b11, 16'hA55A});
  endtask

  task automatic t_lanes();
    cyc(1, 0, 1, 0, 1, 0, 0, 8'h20, 0, 16'h1122);
    cyc(1, 0, 1, 0, 1, 0, 1, 8'h20, 0, 16'hEEDD);
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h20, 0, 16'h0);
    chk("R3 lower lane only", obs(), {1'b0, 2'b11, 16'h11DD});
    cyc(1, 0, 1, 0, 1, 1, 0, 8'h20, 0, 16'h99FF);
    cyc(1, 0, 1, 1, 0, 1, 0, 8'h20, 0, 16'h0);
    chk("R4 upper lane drive", obs(), {1'b0, 2'b10, 16'h9900});
    cyc(1, 0, 1, 1, 0, 0, 1, 8'h20, 0, 16'h0);
    chk("R4 lower lane drive", obs(), {1'b0, 2'b01, 16'h00DD});
  endtask

  task automatic t_deselect();
    cyc(1, 1, 1, 0, 0, 0, 0, 8'h30, 0, 16'hDEAD);
    chk("R2 en_low_n high", obs(), {1'b1, 2'b00, 16'h0000});
    cyc(1, 0, 0, 0, 0, 0, 0, 8'h30, 0, 16'hDEAD);
    chk("R2 en_high low", obs(), {1'b1, 2'b00, 16'h0000});
    cyc(1, 1, 0, 1, 0, 0, 0, 8'h12, 0, 16'h0);
    chk("R2 both inactive on read", obs(), {1'b1, 2'b00, 16'h0000});
    cyc(1, 0, 1, 1, 1, 0, 0, 8'h12, 0, 16'h0);
    chk("R10 selected without drive", obs(), {1'b0, 2'b00, 16'h0000});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h12, 0, 16'h0);
    chk("R2/R10 array unchanged", obs(), {1'b0, 2'b11, 16'hA55A});
  endtask

  task automatic t_write_drive();
    cyc(1, 0, 1, 0, 0, 0, 0, 8'h40, 0, 16'h4321);
    chk("R5 no drive during write", obs(), {1'b0, 2'b00, 16'h0000});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h40, 0, 16'h0);
    chk("R5 write stored", obs(), {1'b0, 2'b11, 16'h4321});
  endtask

  task automatic t_no_lanes();
    cyc(1, 0, 1, 0, 0, 1, 1, 8'h40, 0, 16'hFFFF);
    chk("R6 no lanes idle", obs(), {1'b1, 2'b00, 16'h0000});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h40, 0, 16'h0);
    chk("R6 no write without lanes", obs(), {1'b0, 2'b11, 16'h4321});
  endtask

  task automatic t_byte();
    cyc(0, 0, 1, 0, 1, 1, 1, 8'h50, 0, 16'hAB3C);
    cyc(0, 0, 1, 0, 1, 1, 1, 8'h50, 1, 16'hCD7E);
    cyc(0, 0, 1, 1, 0, 1, 1, 8'h50, 0, 16'h0);
    chk("R8 byte read low half", obs(), {1'b0, 2'b01, 16'h003C});
    cyc(0, 0, 1, 1, 0, 0, 0, 8'h50, 1, 16'h0);
    chk("R8 byte read high half", obs(), {1'b0, 2'b01, 16'h007E});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h50, 0, 16'h0);
    chk("R7 halves in one word", obs(), {1'b0, 2'b11, 16'h7E3C});
    cyc(0, 0, 1, 1, 0, 0, 0, 8'h40, 1, 16'h0);
    chk("R7 word data by byte", obs(), {1'b0, 2'b01, 16'h0043});
    cyc(0, 0, 1, 0, 0, 0, 0, 8'h40, 0, 16'h0099);
    chk("R5/R8 byte write quiet", obs(), {1'b0, 2'b00, 16'h0000});
    cyc(1, 0, 1, 1, 0, 0, 0, 8'h40, 0, 16'h0);
    chk("R7 byte write keeps other half", obs(), {1'b0, 2'b11, 16'h4399});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wide_mode = 1; en_low_n = 1; en_high = 0; write_n = 1; drive_n = 1;
    lane_lo_n = 1; lane_hi_n = 1; addr = '0; half_sel = 0; wdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_rw();
    t_lanes();
    t_deselect();
    t_write_drive();
    t_no_lanes();
    t_byte();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule